// File: doc/BRIEF.md
# Programmable Divider and Timer

This block keeps time for a small processor subsystem. A free-running tick counter advances on every machine-cycle tick. A divider register steps once every 64 ticks. An 8-bit timer counter steps at one of four rates picked by a 2-bit rate field. When the counter wraps past 0xFF it is reloaded from a modulo register rather than from zero, and the block sends a one-cycle interrupt request to an external interrupt controller.

Software reaches the four registers through a byte-wide port. The port has a 2-bit register select, a write strobe with write data, and a read strobe with combinational read data. Select 0 is the divider, 1 the counter, 2 the modulo and 3 the control register. Control bit 2 enables the counter, bits 1:0 pick the rate, and bits 7:3 read as 1. A write of any value to the divider clears both the divider and the tick counter, which restarts the rate phase.

Top module: `tick_timer`

## Requirements
- R1: After reset the divider, counter and modulo read 0x00, the control register reads 0xF8 and the interrupt request is low.
- R2: The divider steps by one on every 64th tick counted from a cleared tick counter, and holds between those ticks and while tick is low.
- R3: A write of any value to the divider (select 0) sets it to 0x00 and restarts the tick counter, so the next counter step of rate field 1 comes 4 ticks later.
- R4: With the enable bit (control bit 2) clear, the counter does not change however many ticks arrive.
- R5: With the enable bit set, rate field values 0, 1, 2 and 3 (control bits 1:0) step the counter every 256, 4, 16 and 64 ticks from a cleared tick counter.
- R6: A counter step from 0xFF loads the modulo register value into the counter.
- R7: The interrupt request goes high for exactly one cycle, in the same cycle in which the reloaded counter value appears, and at no other time.
- R8: A counter write (select 1) made in the same cycle as an overflow step wins: the counter takes the written value, no reload happens and no interrupt is raised.
- R9: Reads return the selected register while the read strobe is high and 0x00 while it is low. Control bits 7:3 always read as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Machine-cycle tick enable |
| reg_sel_i | input | 2 | Register select: 0 divider, 1 counter, 2 modulo, 3 control |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data (combinational) |
| irq_o | output | 1 | One-cycle timer interrupt request |

## Verification
The hardest case to reach is a counter write landing in the same cycle as the tick that would overflow the counter. The bench gets there by loading the counter with 0xFF and clearing the divider to fix the rate phase. It then gives exactly three ticks at rate 1, so the fourth tick is the overflow step. On that tick it raises the tick input and the counter write strobe on the same falling edge. Every other rate and overflow test also starts from a divider clear, so the tick on which each step falls is known exactly.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   typedef enum logic [1:0] {
      RSEL_DIV = 2'd0,
      RSEL_CNT = 2'd1,
      RSEL_MOD = 2'd2,
      RSEL_CTL = 2'd3
   } reg_sel_e;

   localparam int CTL_EN_BIT   = 2;
   localparam int CTL_RATE_LSB = 0;
endpackage

// File: rtl/tick_base.sv
// Shared tick counter and divider register.
module tick_base #(
   parameter int TICK_W   = 8,
   parameter int DIV_LOG2 = 6,
   parameter int DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              clear_i,
   output logic              step_o,
   output logic [TICK_W-1:0] tick_next_o,
   output logic [DATA_W-1:0] div_o
);
   generate
      if (DIV_LOG2 < 1 || DIV_LOG2 > TICK_W) begin : g_bad_div
         $error("DIV_LOG2 must lie in 1..TICK_W");
      end
   endgenerate

   logic [TICK_W-1:0] tick_q;
   logic [DATA_W-1:0] div_q;

   assign step_o      = tick_i && !clear_i;
   assign tick_next_o = tick_q + TICK_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         tick_q <= '0;
         div_q  <= '0;
      end else if (tick_i) begin
         tick_q <= tick_next_o;
         if (tick_next_o[DIV_LOG2-1:0] == '0)
            div_q <= div_q + DATA_W'(1);
      end
   end

   assign div_o = div_q;
endmodule

// File: rtl/tick_rate.sv
// Rate selection: a step fires when the advanced tick count is zero under the selected mask.
module tick_rate #(
   parameter int TICK_W    = 8,
   parameter int SEL0_LOG2 = 8,
   parameter int SEL1_LOG2 = 2,
   parameter int SEL2_LOG2 = 4,
   parameter int SEL3_LOG2 = 6
) (
   input  logic              step_i,
   input  logic              enable_i,
   input  logic [1:0]        rate_i,
   input  logic [TICK_W-1:0] tick_next_i,
   output logic              fire_o
);
   logic [TICK_W-1:0] mask_tab [4];

   generate
      for (genvar g = 0; g < 4; g++) begin : g_mask
         localparam int LG = (g == 0) ? SEL0_LOG2 :
                             (g == 1) ? SEL1_LOG2 :
                             (g == 2) ? SEL2_LOG2 : SEL3_LOG2;
         if (LG < 1 || LG > TICK_W) begin : g_bad_lg
            $error("rate exponent out of range for tick counter width");
         end
         assign mask_tab[g] = TICK_W'((64'd1 << LG) - 64'd1);
      end
   endgenerate

   assign fire_o = step_i && enable_i && ((tick_next_i & mask_tab[rate_i]) == '0);
endmodule

// File: rtl/tick_count.sv
// Timer counter with modulo reload and interrupt pulse.
module tick_count #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic              cnt_wr_i,
   input  logic              mod_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] cnt_o,
   output logic [DATA_W-1:0] mod_o,
   output logic              irq_o
);
   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] mod_q;
   logic              irq_q;
   logic              wrap;

   assign wrap = fire_i && (cnt_q == '1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mod_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= wrap && !cnt_wr_i;
         if (cnt_wr_i)
            cnt_q <= wdata_i;
         else if (wrap)
            cnt_q <= mod_q;
         else if (fire_i)
            cnt_q <= cnt_q + DATA_W'(1);
         if (mod_wr_i)
            mod_q <= wdata_i;
      end
   end

   assign cnt_o = cnt_q;
   assign mod_o = mod_q;
   assign irq_o = irq_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int TICK_W    = 8,
   parameter int DIV_LOG2  = 6,
   parameter int SEL0_LOG2 = 8,
   parameter int SEL1_LOG2 = 2,
   parameter int SEL2_LOG2 = 4,
   parameter int SEL3_LOG2 = 6,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [1:0]        reg_sel_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o
);
   localparam int CTL_USED = 3;

   generate
      if (DATA_W <= CTL_USED) begin : g_bad_width
         $error("DATA_W must exceed the control field width");
      end
   endgenerate

   reg_sel_e          sel;
   logic              div_wr, cnt_wr, mod_wr, ctl_wr;
   logic              step, fire;
   logic [TICK_W-1:0] tick_next;
   logic [DATA_W-1:0] div_val, cnt_val, mod_val;
   logic              ctl_en;
   logic [1:0]        ctl_rate;

   assign sel    = reg_sel_e'(reg_sel_i);
   assign div_wr = wr_en_i && (sel == RSEL_DIV);
   assign cnt_wr = wr_en_i && (sel == RSEL_CNT);
   assign mod_wr = wr_en_i && (sel == RSEL_MOD);
   assign ctl_wr = wr_en_i && (sel == RSEL_CTL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_en   <= 1'b0;
         ctl_rate <= 2'd0;
      end else if (ctl_wr) begin
         ctl_en   <= wr_data_i[CTL_EN_BIT];
         ctl_rate <= wr_data_i[CTL_RATE_LSB +: 2];
      end
   end

   tick_base #(.TICK_W(TICK_W), .DIV_LOG2(DIV_LOG2), .DATA_W(DATA_W)) u_base (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .clear_i     (div_wr),
      .step_o      (step),
      .tick_next_o (tick_next),
      .div_o       (div_val)
   );

   tick_rate #(
      .TICK_W(TICK_W), .SEL0_LOG2(SEL0_LOG2), .SEL1_LOG2(SEL1_LOG2),
      .SEL2_LOG2(SEL2_LOG2), .SEL3_LOG2(SEL3_LOG2)
   ) u_rate (
      .step_i      (step),
      .enable_i    (ctl_en),
      .rate_i      (ctl_rate),
      .tick_next_i (tick_next),
      .fire_o      (fire)
   );

   tick_count #(.DATA_W(DATA_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire_i   (fire),
      .cnt_wr_i (cnt_wr),
      .mod_wr_i (mod_wr),
      .wdata_i  (wr_data_i),
      .cnt_o    (cnt_val),
      .mod_o    (mod_val),
      .irq_o    (irq_o)
   );

   always_comb begin
      rd_data_o = '0;
      if (rd_en_i) begin
         unique case (sel)
            RSEL_DIV: rd_data_o = div_val;
            RSEL_CNT: rd_data_o = cnt_val;
            RSEL_MOD: rd_data_o = mod_val;
            RSEL_CTL: rd_data_o = {{(DATA_W-CTL_USED){1'b1}}, ctl_en, ctl_rate};
         endcase
      end
   end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic [1:0]        reg_sel_i,
   input logic              wr_en_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic              irq_o,
   input logic [DATA_W-1:0] cnt_q,
   input logic [DATA_W-1:0] div_q,
   input logic [DATA_W-1:0] mod_q,
   input logic              en_q
);
   // R7: the request never lasts two cycles
   p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R6: the request comes with the reload value from the modulo register
   p_irq_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (cnt_q == $past(mod_q)));

   // R2: the divider holds without a tick or a divider write
   p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !(wr_en_i && reg_sel_i == 2'd0)) |=> $stable(div_q));

   // R3: a divider write clears it
   p_div_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && reg_sel_i == 2'd0) |=> (div_q == '0));

   // R4: a disabled counter holds unless written
   p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !(wr_en_i && reg_sel_i == 2'd1)) |=> $stable(cnt_q));

   // R8: a counter write wins over any overflow
   p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && reg_sel_i == 2'd1) |=> (cnt_q == $past(wr_data_i) && !irq_o));
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .reg_sel_i (reg_sel_i),
   .wr_en_i   (wr_en_i),
   .wr_data_i (wr_data_i),
   .irq_o     (irq_o),
   .cnt_q     (cnt_val),
   .div_q     (div_val),
   .mod_q     (mod_val),
   .en_q      (ctl_en)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic [1:0] reg_sel_i = 2'd0;
   logic       wr_en_i = 1'b0;
   logic       rd_en_i = 1'b0;
   logic [7:0] wr_data_i = 8'h00;
   logic [7:0] rd_data_o;
   logic       irq_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   tick_timer uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reg_sel_i(reg_sel_i),
      .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .wr_data_i(wr_data_i),
      .rd_data_o(rd_data_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, actual, expected);
      end
   endtask

   task automatic do_ticks(input int n);
      if (n > 0) begin
         @(negedge clk);
         tick_i = 1'b1;
         repeat (n) @(negedge clk);
         tick_i = 1'b0;
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      reg_sel_i = s; wr_data_i = d; wr_en_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] d);
      reg_sel_i = s; rd_en_i = 1'b1;
      #1 d = rd_data_o;
      rd_en_i = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      rd(2'd0, v); check("R1 divider", v, 8'h00);
      rd(2'd1, v); check("R1 counter", v, 8'h00);
      rd(2'd2, v); check("R1 modulo", v, 8'h00);
      rd(2'd3, v); check("R1 control", v, 8'hF8);
      check("R1 irq", irq_o, 0);
      reg_sel_i = 2'd3; rd_en_i = 1'b0; #1;
      check("R9 idle read is zero", rd_data_o, 8'h00);
   endtask

   task automatic t_divider;
      logic [7:0] v;
      wr(2'd0, 8'h00);
      do_ticks(63); rd(2'd0, v); check("R2 divider before 64", v, 8'h00);
      do_ticks(1);  rd(2'd0, v); check("R2 divider at 64", v, 8'h01);
      repeat (5) @(negedge clk);
      rd(2'd0, v); check("R2 divider holds without tick", v, 8'h01);
      do_ticks(64); rd(2'd0, v); check("R2 divider at 128", v, 8'h02);
   endtask

   task automatic t_disabled;
      logic [7:0] v;
      wr(2'd1, 8'h00);
      wr(2'd3, 8'h01);
      do_ticks(300); rd(2'd1, v); check("R4 counter holds when disabled", v, 8'h00);
   endtask

   task automatic t_rates;
      logic [7:0] v;
      int per;
      for (int s = 0; s < 4; s++) begin
         per = (s == 0) ? 256 : (s == 1) ? 4 : (s == 2) ? 16 : 64;
         wr(2'd3, 8'h04 | 8'(s));
         wr(2'd1, 8'h00);
         wr(2'd0, 8'h00);
         do_ticks(per - 1); rd(2'd1, v); check($sformatf("R5 rate %0d before period", s), v, 8'h00);
         do_ticks(1);       rd(2'd1, v); check($sformatf("R5 rate %0d at period", s), v, 8'h01);
         do_ticks(per);     rd(2'd1, v); check($sformatf("R5 rate %0d second period", s), v, 8'h02);
      end
   endtask

   task automatic t_phase_restart;
      logic [7:0] v;
      wr(2'd3, 8'h05);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h00);
      do_ticks(3);
      wr(2'd0, 8'hA5);
      rd(2'd0, v); check("R3 divider write clears", v, 8'h00);
      do_ticks(3); rd(2'd1, v); check("R3 phase restarted", v, 8'h00);
      do_ticks(1); rd(2'd1, v); check("R3 step after 4 ticks", v, 8'h01);
   endtask

   task automatic t_overflow;
      logic [7:0] v;
      wr(2'd3, 8'h05);
      wr(2'd2, 8'h37);
      wr(2'd1, 8'hFE);
      wr(2'd0, 8'h00);
      do_ticks(7); rd(2'd1, v); check("R6 counter at FF", v, 8'hFF);
      check("R7 no irq before wrap", irq_o, 0);
      do_ticks(1);
      check("R7 irq with reload", irq_o, 1);
      rd(2'd1, v); check("R6 reload from modulo", v, 8'h37);
      @(negedge clk);
      check("R7 irq one cycle", irq_o, 0);
      do_ticks(4); rd(2'd1, v); check("R6 counts on from reload", v, 8'h38);
      check("R7 no irq on plain step", irq_o, 0);
   endtask

   task automatic t_write_wins;
      logic [7:0] v;
      wr(2'd3, 8'h05);
      wr(2'd2, 8'h37);
      wr(2'd1, 8'hFF);
      wr(2'd0, 8'h00);
      do_ticks(3);
      @(negedge clk);
      tick_i = 1'b1; reg_sel_i = 2'd1; wr_data_i = 8'h10; wr_en_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0; wr_en_i = 1'b0;
      check("R8 no irq when write wins", irq_o, 0);
      rd(2'd1, v); check("R8 written value kept", v, 8'h10);
   endtask

   task automatic t_ctl_read;
      logic [7:0] v;
      wr(2'd3, 8'h06);
      rd(2'd3, v); check("R9 control readback", v, 8'hFE);
      wr(2'd3, 8'h00);
      rd(2'd3, v); check("R9 control upper ones", v, 8'hF8);
      rd(2'd2, v); check("R9 modulo readback", v, 8'h37);
   endtask

   initial begin
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_divider();
      t_disabled();
      t_rates();
      t_phase_restart();
      t_overflow();
      t_write_wins();
      t_ctl_read();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule